// File: doc/BRIEF.md
# Start-Triggered Run Counter with Status Flags

This block pairs a three-state controller with a small datapath: a counter and two single-bit flags, here called the bit flag and the done flag. While the controller is idle, it waits for a start request. The start request zeroes the counter and the done flag, and then a counting run begins. During the run the counter advances once per clock. On each of those clocks, the bit flag takes the value that counter bit 2 had before the edge. The run ends on the clock where counter bits 3 and 2 are both high. The controller then spends one clock in a flag state, raises the done flag and returns to idle.

Every register operation for a state takes effect on the same clock edge as the state change. This includes the operations that depend on a condition. The present state is driven out as a fixed two-bit code. The spare code 2'b10 leads back to idle, so that a corrupted state register recovers on its own. A run that starts from zero therefore stays in the run state for thirteen clocks, and it leaves the counter at 13.

Top module: `startrun_counter`

## Requirements
- R1: While reset is held, the state output is 2'b00 (idle), the count is 0, and both the bit flag and the done flag are 0.
- R2: In idle with start low, the state, the count, the bit flag and the done flag all keep their values on every clock.
- R3: In idle with start high, the next clock gives state 2'b01 (run), a count of 0 and a done flag of 0, and the bit flag is left unchanged.
- R4: In the run state, the count increases by exactly one on every clock.
- R5: In the run state, on each clock the bit flag is loaded with the value that count bit 2 had before that clock.
- R6: In the run state, when count bits 3 and 2 are both 1, the next state is 2'b11 (flag). Otherwise the state stays at run.
- R7: In the flag state, the next clock sets the done flag to 1, returns the state to idle and leaves the count and the bit flag unchanged.
- R8: A run that starts from a count of 0 spends exactly 13 clocks in the run state. When it is back in idle, the count is 13, the bit flag is 1 and the done flag is 1.
- R9: The start input has no effect in the run and flag states. A start that is held high through the flag state begins a new run on the first clock in idle.
- R10: The state output only ever shows the codes 2'b00, 2'b01 and 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run request, sampled in idle only |
| count_o | output | CNT_W (4) | Counter value |
| bit_flag_o | output | 1 | Flag that follows counter bit 2 during a run |
| done_flag_o | output | 1 | Set when a run completes, cleared on start |
| state_o | output | 2 | Present state code: 00 idle, 01 run, 11 flag |

## Verification
The hardest case to reach from the ports is a restart on the very first idle clock after a run has finished. To reach it, start must stay high through the whole run and the flag state, so that the start is ignored until idle is reached. The bench holds start high for an entire run and then checks three things on the next edge: a new run begins at once, the done flag drops, and the bit flag keeps the 1 it carried over. The spare state code cannot be reached from the ports, so its recovery path is covered only by the checker's property that the code never appears.

// File: rtl/srcnt_pkg.sv
`timescale 1ns/1ps
package srcnt_pkg;

    // Fixed state codes; 2'b10 is the spare code and steers back to idle
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_RUN   = 2'b01,
        ST_SPARE = 2'b10,
        ST_FLAG  = 2'b11
    } state_e;

    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_cmd_t;

    typedef struct packed {
        logic bit_load;
        logic done_clr;
        logic done_set;
    } flag_cmd_t;

    typedef struct packed {
        logic bit_flag;
        logic done_flag;
    } flag_regs_t;

endpackage

// File: rtl/srcnt_ctrl.sv
`timescale 1ns/1ps
module srcnt_ctrl
    import srcnt_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      start_i,
    input  logic      term_hi_i,
    input  logic      term_lo_i,
    output state_e    state_o,
    output cnt_cmd_t  cnt_cmd_o,
    output flag_cmd_t flag_cmd_o
);

    state_e state_d, state_q;

    always_comb begin
        state_d    = state_q;
        cnt_cmd_o  = '0;
        flag_cmd_o = '0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    cnt_cmd_o.clr       = 1'b1;
                    flag_cmd_o.done_clr = 1'b1;
                    state_d             = ST_RUN;
                end
            end
            ST_RUN: begin
                cnt_cmd_o.inc       = 1'b1;
                flag_cmd_o.bit_load = 1'b1;
                if (term_hi_i && term_lo_i) begin
                    state_d = ST_FLAG;
                end
            end
            ST_FLAG: begin
                flag_cmd_o.done_set = 1'b1;
                state_d             = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/srcnt_counter.sv
`timescale 1ns/1ps
module srcnt_counter
    import srcnt_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  cnt_cmd_t         cmd_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (cmd_i.clr) begin
            count_d = '0;
        end else if (cmd_i.inc) begin
            count_d = count_q + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/srcnt_flags.sv
`timescale 1ns/1ps
module srcnt_flags
    import srcnt_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  flag_cmd_t cmd_i,
    input  logic      bit_src_i,
    output logic      bit_flag_o,
    output logic      done_flag_o
);

    flag_regs_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (cmd_i.bit_load) begin
            flags_d.bit_flag = bit_src_i;
        end
        if (cmd_i.done_clr) begin
            flags_d.done_flag = 1'b0;
        end else if (cmd_i.done_set) begin
            flags_d.done_flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign bit_flag_o  = flags_q.bit_flag;
    assign done_flag_o = flags_q.done_flag;

endmodule

// File: rtl/startrun_counter.sv
`timescale 1ns/1ps
module startrun_counter
    import srcnt_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int HI_POS  = 3,
    parameter int LO_POS  = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output logic [CNT_W-1:0] count_o,
    output logic             bit_flag_o,
    output logic             done_flag_o,
    output logic [1:0]       state_o
);

    state_e    state;
    cnt_cmd_t  cnt_cmd;
    flag_cmd_t flag_cmd;
    logic [CNT_W-1:0] count;

    srcnt_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .term_hi_i  (count[HI_POS]),
        .term_lo_i  (count[LO_POS]),
        .state_o    (state),
        .cnt_cmd_o  (cnt_cmd),
        .flag_cmd_o (flag_cmd)
    );

    srcnt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cmd_i   (cnt_cmd),
        .count_o (count)
    );

    srcnt_flags u_flags (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_i       (flag_cmd),
        .bit_src_i   (count[LO_POS]),
        .bit_flag_o  (bit_flag_o),
        .done_flag_o (done_flag_o)
    );

    assign count_o = count;
    assign state_o = state;

endmodule

// File: rtl/startrun_counter_chk.sv
`timescale 1ns/1ps
module startrun_counter_chk #(
    parameter int CNT_W  = 4,
    parameter int HI_POS = 3,
    parameter int LO_POS = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic [CNT_W-1:0] count_o,
    input logic             bit_flag_o,
    input logic             done_flag_o,
    input logic [1:0]       state_o
);

    localparam logic [1:0] S_IDLE = 2'b00;
    localparam logic [1:0] S_RUN  = 2'b01;
    localparam logic [1:0] S_FLAG = 2'b11;

    a_r10_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o != 2'b10);

    a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == S_IDLE && !start_i) |=> (state_o == S_IDLE && $stable(count_o)
            && $stable(bit_flag_o) && $stable(done_flag_o)));

    a_r3_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == S_IDLE && start_i) |=> (state_o == S_RUN && count_o == '0
            && !done_flag_o && $stable(bit_flag_o)));

    a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == S_RUN) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

    a_r5_bit_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == S_RUN) |=> (bit_flag_o == $past(count_o[LO_POS])));

    a_r6_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == S_RUN && count_o[HI_POS] && count_o[LO_POS]) |=> (state_o == S_FLAG));

    a_r6_stay: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == S_RUN && !(count_o[HI_POS] && count_o[LO_POS])) |=> (state_o == S_RUN));

    a_r7_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == S_FLAG) |=> (state_o == S_IDLE && done_flag_o
            && $stable(count_o) && $stable(bit_flag_o)));

endmodule

bind startrun_counter startrun_counter_chk #(
    .CNT_W  (CNT_W),
    .HI_POS (HI_POS),
    .LO_POS (LO_POS)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .count_o     (count_o),
    .bit_flag_o  (bit_flag_o),
    .done_flag_o (done_flag_o),
    .state_o     (state_o)
);

// File: tb/startrun_counter_tb_top.sv
`timescale 1ns/1ps
module startrun_counter_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] count_o;
    logic       bit_flag_o;
    logic       done_flag_o;
    logic [1:0] state_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk_i = ~clk_i;

    startrun_counter dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .count_o     (count_o),
        .bit_flag_o  (bit_flag_o),
        .done_flag_o (done_flag_o),
        .state_o     (state_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic step();
        @(posedge clk_i);
        #1;
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_ni  = 1'b0;
        start_i = 1'b0;
        #1;
        chk_eq("R1 state", state_o, 0);
        chk_eq("R1 count", count_o, 0);
        chk_eq("R1 bit flag", bit_flag_o, 0);
        chk_eq("R1 done flag", done_flag_o, 0);
        step();
        step();
        rst_ni = 1'b1;
    endtask

    // R2: idle hold without start
    task automatic t_idle_hold();
        start_i = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step();
            chk_eq("R2 state", state_o, 0);
            chk_eq("R2 count", count_o, 0);
            chk_eq("R2 done flag", done_flag_o, 0);
        end
    endtask

    // One run from a count of 0; start_hold drives start during the run (R9)
    task automatic run_from_zero(input bit start_hold);
        int run_clocks = 0;
        for (int i = 0; i < 13; i++) begin
            start_i = start_hold;
            chk_eq("R4 count before edge", count_o, i);
            step();
            run_clocks++;
            chk_eq("R4 count step", count_o, i + 1);
            chk_eq("R5 bit flag", bit_flag_o, (i >> 2) & 1);
            chk_eq("R6 state", state_o, (i == 12) ? 3 : 1);
            chk_eq("R9 done flag stays low", done_flag_o, 0);
        end
        chk_eq("R8 run clocks", run_clocks, 13);
        step();
        chk_eq("R7 state idle", state_o, 0);
        chk_eq("R7 done flag set", done_flag_o, 1);
        chk_eq("R8 final count", count_o, 13);
        chk_eq("R8 final bit flag", bit_flag_o, 1);
    endtask

    // R3 and R8: one plain run
    task automatic t_first_run();
        start_i = 1'b1;
        step();
        chk_eq("R3 state run", state_o, 1);
        chk_eq("R3 count zero", count_o, 0);
        chk_eq("R3 done flag clear", done_flag_o, 0);
        chk_eq("R3 bit flag kept", bit_flag_o, 0);
        start_i = 1'b0;
        run_from_zero(1'b0);
        step();
        chk_eq("R2 hold after run state", state_o, 0);
        chk_eq("R2 hold after run done", done_flag_o, 1);
    endtask

    // R9: start held through a whole run restarts at once
    task automatic t_held_start();
        start_i = 1'b1;
        step();
        chk_eq("R3 relaunch count", count_o, 0);
        chk_eq("R3 relaunch done clear", done_flag_o, 0);
        chk_eq("R3 relaunch bit kept", bit_flag_o, 1);
        run_from_zero(1'b1);
        step();
        chk_eq("R9 immediate restart state", state_o, 1);
        chk_eq("R9 immediate restart count", count_o, 0);
        chk_eq("R9 immediate restart done", done_flag_o, 0);
        chk_eq("R9 immediate restart bit", bit_flag_o, 1);
        start_i = 1'b0;
        run_from_zero(1'b0);
    endtask

    // R1: reset in the middle of a run
    task automatic t_reset_midrun();
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        for (int i = 0; i < 6; i++) step();
        chk_eq("R4 midrun count", count_o, 6);
        rst_ni = 1'b0;
        #1;
        chk_eq("R1 midrun state", state_o, 0);
        chk_eq("R1 midrun count", count_o, 0);
        chk_eq("R1 midrun bit flag", bit_flag_o, 0);
        chk_eq("R1 midrun done flag", done_flag_o, 0);
        step();
        rst_ni = 1'b1;
        step();
        chk_eq("R2 idle after reset", state_o, 0);
    endtask

    // R10: state code watch on every sample point
    always @(negedge clk_i) begin
        if (rst_ni && state_o == 2'b10) begin
            n_checks++;
            n_fails++;
            $display("FAIL R10: actual %0d expected not 2", state_o);
        end
    end

    initial begin
        #80000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle_hold();
        t_first_run();
        t_held_start();
        t_reset_midrun();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule